// File: doc/BRIEF.md
# UART FIFO Control with DMA Handshake

This block is the FIFO side of one UART channel. It holds a transmit queue and a receive queue of 32 bytes each. A single write port sets the control byte: the FIFO enable, two one-shot queue flushes, a DMA signalling mode and two 2-bit trigger codes. From these the block works out a fill threshold for each direction. It raises a trigger flag when that threshold is met and drives two active-low DMA request outputs.

The host pushes transmit bytes and pops receive bytes. The serial side pops transmit bytes and pushes received bytes, and it pulses a time-out strobe when a partial receive burst has gone idle. Four 8-bit override registers are written through a small indexed port. When any of them is nonzero, the receive and transmit thresholds come from the first two of them as plain byte counts, in place of the coded levels.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After a synchronous reset both queues are empty and disabled, the control byte and override registers are zero, overflow flags are 0, pop data is 0, `rx_ready_n`=1, `tx_ready_n`=0, `rx_trig`=0 and `tx_trig`=1.
- R2: A control write stores bit 0 as the enable (`fifo_en`). A write that changes the enable empties both queues and clears both overflow flags on that edge.
- R3: A control write with bit 1 set empties the receive queue and clears its overflow flag on that edge. The bit is not kept: the next write without it does not flush.
- R4: A control write with bit 2 set does the same for the transmit queue and its overflow flag.
- R5: With the queues enabled and no override active, `rx_trig` is 1 exactly when the receive fill is at least the level coded by bits 7:6: 00 gives 8, 01 gives 16, 10 gives 24, 11 gives 28.
- R6: With the queues enabled and no override active, `tx_trig` is 1 exactly when the free transmit space is at least the level coded by bits 5:4: 00 gives 16, 01 gives 8, 10 gives 24, 11 gives 30.
- R7: Override registers are written with `ovr_we` and index `ovr_sel` (0 receive level, 1 transmit level, 2 and 3 flow-control thresholds). While any of the four is nonzero, R5 and R6 use register 0 and register 1 as the levels.
- R8: While disabled, each queue holds at most one byte, and both levels are 1 whatever the codes and overrides are.
- R9: A push is taken only when the fill is below capacity at that edge. A refused push is dropped and sets that queue's sticky overflow flag, which only a flush clears. The fill never exceeds 32.
- R10: Bytes pop in push order. Pop data is registered and appears the cycle after the pop. A pop from an empty queue leaves the data and the fill unchanged.
- R11: Fill counts are 6 bits wide. An accepted push and an accepted pop on the same edge leave the count unchanged.
- R12: In DMA mode 1 (enable and bit 3 both set), `rx_ready_n` is driven low one cycle after the receive trigger or `rx_timeout` is seen. It stays low until a cycle in which the receive queue is seen empty, and rises on the following edge.
- R13: In DMA mode 1, `tx_ready_n` is driven high one cycle after the transmit queue is seen full. It stays high until a cycle in which the transmit trigger is seen, and falls on the following edge.
- R14: Outside mode 1, `rx_ready_n` is low whenever the receive queue holds a byte, and `tx_ready_n` is low whenever the transmit queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte |
| ovr_we | input | 1 | Override register write strobe |
| ovr_sel | input | 2 | Override register index |
| ovr_wdata | input | 8 | Override register value |
| tx_push | input | 1 | Host writes a transmit byte |
| tx_push_data | input | 8 | Transmit byte in |
| tx_pop | input | 1 | Serial side takes a transmit byte |
| tx_pop_data | output | 8 | Last transmit byte taken |
| rx_push | input | 1 | Serial side delivers a received byte |
| rx_push_data | input | 8 | Received byte in |
| rx_pop | input | 1 | Host reads a received byte |
| rx_pop_data | output | 8 | Last received byte read |
| rx_timeout | input | 1 | Receive idle time-out strobe |
| fifo_en | output | 1 | Current enable bit |
| tx_level | output | 6 | Transmit fill count |
| rx_level | output | 6 | Receive fill count |
| tx_trig | output | 1 | Transmit free space at or above level |
| rx_trig | output | 1 | Receive fill at or above level |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_ovf | output | 1 | Sticky receive overflow |
| tx_ready_n | output | 1 | Active-low transmit DMA request |
| rx_ready_n | output | 1 | Active-low receive DMA request |

## Verification
The hardest states to reach are the hysteresis windows of mode 1. For receive, the fill has dropped below the trigger but the queue is not yet empty, so `rx_ready_n` must stay low. For transmit, the queue has drained from full but not yet down to the coded free space, so `tx_ready_n` must stay high. The stimulus fills each queue to the edge, then drains it one byte at a time while a behavioural model follows every cycle. It also fires a time-out on an empty queue, which gives a one-cycle request. A long random phase mixes pushes, pops, flushes and control rewrites, so that flushes land while a request is held.

// File: rtl/uart_fifo_pkg.sv
// Shared helpers for the UART FIFO control block.
// Assumes the coded trigger tables are meant for 32-entry queues.
package uart_fifo_pkg;

    // Receive threshold selected by the two-bit receive code
    function automatic logic [7:0] rx_code_level(input logic [1:0] code);
        case (code)
            2'b00:   return 8'd8;
            2'b01:   return 8'd16;
            2'b10:   return 8'd24;
            default: return 8'd28;
        endcase
    endfunction

    // Transmit threshold selected by the two-bit transmit code
    function automatic logic [7:0] tx_code_level(input logic [1:0] code);
        case (code)
            2'b00:   return 8'd16;
            2'b01:   return 8'd8;
            2'b10:   return 8'd24;
            default: return 8'd30;
        endcase
    endfunction

endpackage

// File: rtl/uart_fifo_buf.sv
// Circular byte queue with a run-time capacity limit.
// Assumes cap <= DEPTH. A flush wins over push and pop on the same edge.
module uart_fifo_buf #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [CNT_W-1:0]  cap,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  count,
    output logic              ovf
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Accept decisions taken on the fill count at this edge
    always_comb begin
        push_ok = push && (count < cap);
        pop_ok  = pop && (count != '0);
    end

    // Storage array, written on an accepted push
    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wr_ptr] <= push_data;
    end

    // Pointers, count, pop data and the sticky overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            ovf      <= 1'b0;
            pop_data <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok) begin
                rd_ptr   <= bump(rd_ptr);
                pop_data <= mem[rd_ptr];
            end
            if (push && !push_ok) ovf <= 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_trig_sel.sv
// Chooses the receive and transmit thresholds from the codes,
// the override registers and the enable. Purely combinational.
module uart_trig_sel #(
    parameter int LVL_W = 8
) (
    input  logic             en,
    input  logic [1:0]       rx_code,
    input  logic [1:0]       tx_code,
    input  logic             ovr_active,
    input  logic [LVL_W-1:0] ovr_rx,
    input  logic [LVL_W-1:0] ovr_tx,
    output logic [LVL_W-1:0] rx_lvl,
    output logic [LVL_W-1:0] tx_lvl
);
    import uart_fifo_pkg::*;

    // Priority: disabled gives 1, then override, then coded table
    always_comb begin
        if (!en) begin
            rx_lvl = LVL_W'(1);
            tx_lvl = LVL_W'(1);
        end else if (ovr_active) begin
            rx_lvl = ovr_rx;
            tx_lvl = ovr_tx;
        end else begin
            rx_lvl = LVL_W'(rx_code_level(rx_code));
            tx_lvl = LVL_W'(tx_code_level(tx_code));
        end
    end
endmodule

// File: rtl/uart_rdy_latch.sv
// Set/release latch used for the mode-1 DMA request outputs.
// It sets on set_in, holds until release_in and is cleared outside mode 1.
module uart_rdy_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic mode1,
    input  logic set_in,
    input  logic release_in,
    output logic hold
);
    // Hysteresis state, updated from the conditions seen this cycle
    always_ff @(posedge clk) begin
        if (!rst_n || !mode1) hold <= 1'b0;
        else if (hold)        hold <= !release_in;
        else                  hold <= set_in;
    end
endmodule

// File: rtl/uart_fifo_ctrl.sv
// FIFO control for one UART channel: control byte decode, override
// registers, two byte queues, trigger compares and DMA request outputs.
// Assumes one control write at a time. Flush bits act on the write edge.
module uart_fifo_ctrl #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    parameter int LVL_W  = 8,
    parameter int N_OVR  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int SEL_W = $clog2(N_OVR)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_wdata,
    input  logic              ovr_we,
    input  logic [SEL_W-1:0]  ovr_sel,
    input  logic [LVL_W-1:0]  ovr_wdata,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_push_data,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_pop_data,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_push_data,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_pop_data,
    input  logic              rx_timeout,
    output logic              fifo_en,
    output logic [CNT_W-1:0]  tx_level,
    output logic [CNT_W-1:0]  rx_level,
    output logic              tx_trig,
    output logic              rx_trig,
    output logic              tx_ovf,
    output logic              rx_ovf,
    output logic              tx_ready_n,
    output logic              rx_ready_n
);
    logic             dma_q;
    logic [1:0]       rx_code_q, tx_code_q;
    logic [LVL_W-1:0] ovr_q [N_OVR];
    logic             ovr_active, en_flip, rx_clr, tx_clr, mode1;
    logic [CNT_W-1:0] cap, tx_free;
    logic [LVL_W-1:0] rx_lvl, tx_lvl;
    logic             rx_hold, tx_hold;

    // Control byte: enable, DMA mode and the two codes (flush bits not kept)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_en   <= 1'b0;
            dma_q     <= 1'b0;
            rx_code_q <= 2'b00;
            tx_code_q <= 2'b00;
        end else if (ctl_we) begin
            fifo_en   <= ctl_wdata[0];
            dma_q     <= ctl_wdata[3];
            tx_code_q <= ctl_wdata[5:4];
            rx_code_q <= ctl_wdata[7:6];
        end
    end

    // Override registers, one per index
    for (genvar i = 0; i < N_OVR; i++) begin : g_ovr
        always_ff @(posedge clk) begin
            if (!rst_n)                               ovr_q[i] <= '0;
            else if (ovr_we && ovr_sel == SEL_W'(i))  ovr_q[i] <= ovr_wdata;
        end
    end

    // Override is active when any register holds a nonzero value
    always_comb begin
        ovr_active = 1'b0;
        for (int i = 0; i < N_OVR; i++) ovr_active |= (ovr_q[i] != '0);
    end

    // Flush requests, capacity and mode decode
    always_comb begin
        en_flip = ctl_we && (ctl_wdata[0] != fifo_en);
        rx_clr  = (ctl_we && ctl_wdata[1]) || en_flip;
        tx_clr  = (ctl_we && ctl_wdata[2]) || en_flip;
        cap     = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
        mode1   = fifo_en && dma_q;
        tx_free = cap - tx_level;
    end

    uart_trig_sel #(.LVL_W(LVL_W)) u_sel (
        .en(fifo_en), .rx_code(rx_code_q), .tx_code(tx_code_q),
        .ovr_active(ovr_active), .ovr_rx(ovr_q[0]), .ovr_tx(ovr_q[1]),
        .rx_lvl(rx_lvl), .tx_lvl(tx_lvl)
    );

    uart_fifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .cap(cap),
        .push(rx_push), .push_data(rx_push_data), .pop(rx_pop),
        .pop_data(rx_pop_data), .count(rx_level), .ovf(rx_ovf)
    );

    uart_fifo_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .cap(cap),
        .push(tx_push), .push_data(tx_push_data), .pop(tx_pop),
        .pop_data(tx_pop_data), .count(tx_level), .ovf(tx_ovf)
    );

    // Threshold compares: receive on fill, transmit on free space
    always_comb begin
        rx_trig = {{(LVL_W-CNT_W){1'b0}}, rx_level} >= rx_lvl;
        tx_trig = {{(LVL_W-CNT_W){1'b0}}, tx_free} >= tx_lvl;
    end

    uart_rdy_latch u_rx_rdy (
        .clk(clk), .rst_n(rst_n), .mode1(mode1),
        .set_in(rx_trig || rx_timeout), .release_in(rx_level == '0),
        .hold(rx_hold)
    );

    uart_rdy_latch u_tx_rdy (
        .clk(clk), .rst_n(rst_n), .mode1(mode1),
        .set_in(tx_level == cap), .release_in(tx_trig),
        .hold(tx_hold)
    );

    // DMA request outputs: latched in mode 1, plain occupancy otherwise
    always_comb begin
        rx_ready_n = mode1 ? !rx_hold : (rx_level == '0);
        tx_ready_n = mode1 ? tx_hold  : (tx_level != '0);
    end
endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
// Property checker for uart_fifo_ctrl, attached by bind.
// Watches the ports only and assumes the default 8-bit control byte.
module uart_fifo_ctrl_chk #(
    parameter int DEPTH  = 32,
    parameter int CNT_W  = 6,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_we,
    input logic [7:0]        ctl_wdata,
    input logic              fifo_en,
    input logic              rx_push,
    input logic              rx_pop,
    input logic [CNT_W-1:0]  rx_level,
    input logic [CNT_W-1:0]  tx_level,
    input logic              rx_ovf,
    input logic [DATA_W-1:0] rx_pop_data
);
    logic any_rx_flush;
    assign any_rx_flush = ctl_we && (ctl_wdata[1] || (ctl_wdata[0] != fifo_en));

    AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we && ctl_wdata[1] |=> rx_level == '0); // R3
    AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we && ctl_wdata[2] |=> tx_level == '0); // R4
    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (rx_level <= 1) && (tx_level <= 1)); // R8
    AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level <= CNT_W'(DEPTH)) && (tx_level <= CNT_W'(DEPTH))); // R9
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf && !any_rx_flush |=> rx_ovf); // R9
    AST_PUSH_POP_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en && rx_push && rx_pop && rx_level != '0
        && rx_level < CNT_W'(DEPTH) && !any_rx_flush |=> $stable(rx_level)); // R11
    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop && rx_level == '0 |=> $stable(rx_pop_data)); // R10
endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .fifo_en(fifo_en), .rx_push(rx_push), .rx_pop(rx_pop),
    .rx_level(rx_level), .tx_level(tx_level), .rx_ovf(rx_ovf),
    .rx_pop_data(rx_pop_data)
);

// File: tb/uart_fifo_ctrl_tb.sv
module uart_fifo_ctrl_tb;
    logic clk = 0, rst_n = 0;
    logic ctl_we = 0, ovr_we = 0;
    logic [7:0] ctl_wdata = 0, ovr_wdata = 0;
    logic [1:0] ovr_sel = 0;
    logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0, rx_timeout = 0;
    logic [7:0] tx_push_data = 0, rx_push_data = 0, tx_pop_data, rx_pop_data;
    logic fifo_en, tx_trig, rx_trig, tx_ovf, rx_ovf, tx_ready_n, rx_ready_n;
    logic [5:0] tx_level, rx_level;

    int checks = 0, fails = 0;
    bit started = 0, done = 0;

    always #2.5 clk = ~clk; // 200 MHz

    uart_fifo_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ovr_we(ovr_we), .ovr_sel(ovr_sel), .ovr_wdata(ovr_wdata),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .tx_pop(tx_pop),
        .tx_pop_data(tx_pop_data), .rx_push(rx_push), .rx_push_data(rx_push_data),
        .rx_pop(rx_pop), .rx_pop_data(rx_pop_data), .rx_timeout(rx_timeout),
        .fifo_en(fifo_en), .tx_level(tx_level), .rx_level(rx_level),
        .tx_trig(tx_trig), .rx_trig(rx_trig), .tx_ovf(tx_ovf), .rx_ovf(rx_ovf),
        .tx_ready_n(tx_ready_n), .rx_ready_n(rx_ready_n)
    );

    // ---------------- behavioural reference model ----------------
    int m_en, m_dma, m_rxc, m_txc;
    int m_ovr [4];
    byte unsigned m_rxq [$], m_txq [$];
    int m_rx_out, m_tx_out, m_rx_ovf, m_tx_ovf, m_rx_hold, m_tx_hold;

    function automatic int f_cap();
        return m_en ? 32 : 1;
    endfunction
    function automatic bit f_ovr();
        return (m_ovr[0] | m_ovr[1] | m_ovr[2] | m_ovr[3]) != 0;
    endfunction
    function automatic int f_rxlvl();
        int t [4] = '{8, 16, 24, 28};
        if (!m_en) return 1;
        if (f_ovr()) return m_ovr[0];
        return t[m_rxc];
    endfunction
    function automatic int f_txlvl();
        int t [4] = '{16, 8, 24, 30};
        if (!m_en) return 1;
        if (f_ovr()) return m_ovr[1];
        return t[m_txc];
    endfunction
    function automatic bit f_rtrig();
        return m_rxq.size() >= f_rxlvl();
    endfunction
    function automatic bit f_ttrig();
        return (f_cap() - m_txq.size()) >= f_txlvl();
    endfunction
    function automatic bit f_mode1();
        return m_en && m_dma;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_dma = 0; m_rxc = 0; m_txc = 0;
            for (int i = 0; i < 4; i++) m_ovr[i] = 0;
            m_rxq.delete(); m_txq.delete();
            m_rx_out = 0; m_tx_out = 0; m_rx_ovf = 0; m_tx_ovf = 0;
            m_rx_hold = 0; m_tx_hold = 0;
            started = 1;
        end else begin
            int nrh, nth, cap;
            bit flip, rclr, tclr, rpush_ok, rpop_ok, tpush_ok, tpop_ok;
            cap = f_cap();
            if (!f_mode1()) nrh = 0;
            else if (m_rx_hold) nrh = (m_rxq.size() != 0);
            else nrh = f_rtrig() || rx_timeout;
            if (!f_mode1()) nth = 0;
            else if (m_tx_hold) nth = !f_ttrig();
            else nth = (m_txq.size() == cap);
            flip = ctl_we && (ctl_wdata[0] != m_en[0]);
            rclr = (ctl_we && ctl_wdata[1]) || flip;
            tclr = (ctl_we && ctl_wdata[2]) || flip;
            if (rclr) begin
                m_rxq.delete(); m_rx_ovf = 0;
            end else begin
                rpush_ok = rx_push && (m_rxq.size() < cap);
                rpop_ok  = rx_pop && (m_rxq.size() > 0);
                if (rpop_ok) m_rx_out = m_rxq.pop_front();
                if (rpush_ok) m_rxq.push_back(rx_push_data);
                else if (rx_push) m_rx_ovf = 1;
            end
            if (tclr) begin
                m_txq.delete(); m_tx_ovf = 0;
            end else begin
                tpush_ok = tx_push && (m_txq.size() < cap);
                tpop_ok  = tx_pop && (m_txq.size() > 0);
                if (tpop_ok) m_tx_out = m_txq.pop_front();
                if (tpush_ok) m_txq.push_back(tx_push_data);
                else if (tx_push) m_tx_ovf = 1;
            end
            if (ctl_we) begin
                m_en = ctl_wdata[0]; m_dma = ctl_wdata[3];
                m_txc = ctl_wdata[5:4]; m_rxc = ctl_wdata[7:6];
            end
            if (ovr_we) m_ovr[ovr_sel] = ovr_wdata;
            m_rx_hold = nrh; m_tx_hold = nth;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Compare every output against the model on each falling edge
    always @(negedge clk) begin
        if (started && !done) begin
            int erx, etx;
            erx = f_mode1() ? !m_rx_hold : (m_rxq.size() == 0);
            etx = f_mode1() ? m_tx_hold : (m_txq.size() != 0);
            chk(fifo_en == m_en[0], "R2", fifo_en, m_en);
            chk(rx_level == m_rxq.size(), "R11", rx_level, m_rxq.size());
            chk(tx_level == m_txq.size(), "R11", tx_level, m_txq.size());
            chk(rx_pop_data == m_rx_out, "R10", rx_pop_data, m_rx_out);
            chk(tx_pop_data == m_tx_out, "R10", tx_pop_data, m_tx_out);
            chk(rx_ovf == m_rx_ovf[0], "R9", rx_ovf, m_rx_ovf);
            chk(tx_ovf == m_tx_ovf[0], "R9", tx_ovf, m_tx_ovf);
            chk(rx_trig == f_rtrig(), "R5", rx_trig, f_rtrig());
            chk(tx_trig == f_ttrig(), "R6", tx_trig, f_ttrig());
            chk(rx_ready_n == erx[0], "R12", rx_ready_n, erx);
            chk(tx_ready_n == etx[0], "R13", tx_ready_n, etx);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask
    task automatic wr_ctl(input logic [7:0] v);
        ctl_we = 1; ctl_wdata = v; @(negedge clk); ctl_we = 0;
    endtask
    task automatic wr_ovr(input logic [1:0] s, input logic [7:0] v);
        ovr_we = 1; ovr_sel = s; ovr_wdata = v; @(negedge clk); ovr_we = 0;
    endtask
    task automatic rx_in(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            rx_push = 1; rx_push_data = base + 8'(i); @(negedge clk);
        end
        rx_push = 0;
    endtask
    task automatic tx_in(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            tx_push = 1; tx_push_data = base + 8'(i); @(negedge clk);
        end
        tx_push = 0;
    endtask
    task automatic rx_out(input int n);
        rx_pop = 1; idle(n); rx_pop = 0;
    endtask
    task automatic tx_out(input int n);
        tx_pop = 1; idle(n); tx_pop = 0;
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state seen at the ports
        chk(rx_ready_n == 1 && tx_ready_n == 0, "R1", {rx_ready_n, tx_ready_n}, 2);
        chk(rx_trig == 0 && tx_trig == 1, "R1", {rx_trig, tx_trig}, 1);
        chk(rx_level == 0 && tx_level == 0 && !fifo_en, "R1", rx_level, 0);

        // R8 / R14: disabled queues hold one byte; second push dropped (R9)
        rx_in(2, 8'h10);
        chk(rx_level == 1 && rx_ovf, "R8", rx_level, 1);
        tx_in(1, 8'h20);
        chk(tx_ready_n == 1, "R14", tx_ready_n, 1);
        rx_out(1); tx_out(1);
        chk(rx_pop_data == 8'h10, "R10", rx_pop_data, 8'h10);

        // R2: enabling flushes and clears overflow
        rx_in(1, 8'h30);
        wr_ctl(8'h01);
        chk(rx_level == 0 && !rx_ovf && fifo_en, "R2", rx_level, 0);

        // R5 / R3: each receive code, flushing between runs
        for (int c = 0; c < 4; c++) begin
            wr_ctl(8'(c << 6) | 8'h03);
            chk(rx_level == 0, "R3", rx_level, 0);
            rx_in(30, 8'(c * 40));
            rx_out(4);
        end
        // R3: the flush bit is not kept
        wr_ctl(8'h01);
        chk(rx_level == 26, "R3", rx_level, 26);

        // R6 / R9 / R11 / R4: each transmit code, fill past full, drain
        for (int c = 0; c < 4; c++) begin
            wr_ctl(8'(c << 4) | 8'h05);
            chk(tx_level == 0, "R4", tx_level, 0);
            tx_in(33, 8'h40);
            chk(tx_ovf == 1, "R9", tx_ovf, 1);
            tx_pop = 1; tx_push = 1; idle(3); tx_push = 0; tx_pop = 0; // full: push refused
            tx_out(31);
        end
        // R11: push and pop together at mid fill
        wr_ctl(8'h07);
        rx_in(5, 8'h50);
        rx_push = 1; rx_pop = 1; idle(4); rx_push = 0; rx_pop = 0;
        chk(rx_level == 5, "R11", rx_level, 5);

        // R12: mode 1 receive latch, code 00 (level 8)
        wr_ctl(8'h0B);
        rx_in(8, 8'h60);
        idle(1);
        chk(rx_ready_n == 0, "R12", rx_ready_n, 0);
        rx_out(7);
        chk(rx_ready_n == 0, "R12", rx_ready_n, 0);
        rx_out(1); idle(1);
        chk(rx_ready_n == 1, "R12", rx_ready_n, 1);
        rx_timeout = 1; @(negedge clk); rx_timeout = 0;
        chk(rx_ready_n == 0, "R12", rx_ready_n, 0);
        idle(1);
        chk(rx_ready_n == 1, "R12", rx_ready_n, 1);

        // R13: mode 1 transmit latch, code 00 (16 free)
        tx_in(32, 8'h70); idle(1);
        chk(tx_ready_n == 1, "R13", tx_ready_n, 1);
        tx_out(15); idle(1);
        chk(tx_ready_n == 1, "R13", tx_ready_n, 1);
        tx_out(1); idle(1);
        chk(tx_ready_n == 0, "R13", tx_ready_n, 0);

        // R7: overrides replace the coded levels
        wr_ctl(8'h07);
        wr_ovr(2'd0, 8'd5); wr_ovr(2'd1, 8'd3);
        rx_in(5, 8'h80);
        chk(rx_trig == 1, "R7", rx_trig, 1);
        wr_ovr(2'd0, 8'd0); wr_ovr(2'd1, 8'd0); wr_ovr(2'd3, 8'd1);
        chk(rx_trig == 1 && tx_trig == 1, "R7", rx_trig, 1);
        wr_ovr(2'd3, 8'd0);
        chk(rx_trig == 0, "R7", rx_trig, 0);

        // R10: pop from empty keeps data
        wr_ctl(8'h03);
        rx_out(3);

        // Random mix of all functions
        for (int i = 0; i < 4000; i++) begin
            rx_push = $urandom_range(0, 1); rx_push_data = 8'($urandom);
            rx_pop = ($urandom_range(0, 2) == 0);
            tx_push = ($urandom_range(0, 2) != 0); tx_push_data = 8'($urandom);
            tx_pop = $urandom_range(0, 1);
            rx_timeout = ($urandom_range(0, 30) == 0);
            ctl_we = ($urandom_range(0, 120) == 0);
            ctl_wdata = 8'($urandom) | 8'h01;
            if ($urandom_range(0, 8) == 0) ctl_wdata[0] = 0;
            if ($urandom_range(0, 3) != 0) ctl_wdata[2:1] = 0;
            ovr_we = ($urandom_range(0, 300) == 0);
            ovr_sel = 2'($urandom); ovr_wdata = ($urandom_range(0, 1) == 0) ? 8'd0 : 8'($urandom_range(0, 34));
            @(negedge clk);
        end
        {rx_push, rx_pop, tx_push, tx_pop, rx_timeout, ctl_we, ovr_we} = '0;
        idle(4);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule